// File: doc/BRIEF.md
# Flash erase command sequence decoder

This block watches the write cycles a host issues to a NOR-style flash bank and turns the recognised erase command sequences into start signals for an erase engine. It knows two sequences. Both begin with the same five cycles: an unlock pair, a setup command, and a second unlock pair. A sixth cycle then either asks for a whole-bank erase or names a first sector to erase. A wrong cycle part-way through sends the decoder back to read mode without doing anything.

A sector request opens an accept window of `WINDOW` clock cycles. Inside that window the host may add more sectors, in any order and up to every sector of the bank. Each addition restarts the window. An erase-suspend write inside the window is tolerated, and any other write abandons the request. When the window runs out, the gathered sector bitmap is handed over with a one-cycle start pulse and a status bit reports that erasure has begun. While an erase runs, every write is ignored until the engine reports completion on `erase_done`. A hardware reset ends any operation at once.

The write port is a plain per-cycle strobe. It has no back-pressure, because the decoder can accept a write on every clock edge.

Top module: `erase_seq_decoder`

## Requirements
- R1: After `rst`, `chip_erase_start`, `sector_erase_start` and `window_expired` are 0 and `sector_map` is all zeros.
- R2: The six sampled writes (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x10) raise `chip_erase_start` for exactly the one cycle after the edge that samples the sixth write. Addresses are compared on `wr_addr[CMD_AW-1:0]` only.
- R3: A write with the wrong address or data on any of the first five cycles returns the decoder to idle. No output is raised, and a later correct sequence is still recognised.
- R4: A sixth write with data 0x30, at any address, clears `sector_map` and then sets bit `wr_addr[ADDR_W-1 -: SECT_BITS]`, with `ADDR_W = CMD_AW + SECT_BITS`. This write opens the accept window.
- R5: If the window sees no further sector write within `WINDOW` edges after the last accepted one, then at the `WINDOW`-th edge the block does two things. It raises `sector_erase_start` for one cycle. It also sets `window_expired`, which stays 1 until `erase_done` or a hardware reset.
- R6: Each write with data 0x30 inside the window ORs its sector into `sector_map` and restarts the window. Sectors may arrive in any order, and all `2**SECT_BITS` can be selected.
- R7: A write with data 0xB0 (erase suspend) inside the window has no effect. It does not change `sector_map`, does not restart the window and does not abort.
- R8: Any other write inside the window clears `sector_map` and returns to idle. No start pulse follows and `window_expired` stays 0.
- R9: Once the window has expired, writes do not change `sector_map` and do not produce another start pulse.
- R10: After a chip erase starts, all writes are ignored, including complete command sequences, until `erase_done` is seen.
- R11: `hw_reset` aborts a running chip erase, an expired sector erase or an open window. It clears `sector_map` and `window_expired`, and the next sequence is accepted without `erase_done`.
- R12: `sector_map` holds its value after expiry, through `erase_done` and a later chip erase, until the next sector sequence's sixth cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_reset | input | 1 | Hardware reset, synchronous, active high; aborts any operation |
| wr_en | input | 1 | Write strobe, one write per sampled cycle |
| wr_addr | input | ADDR_W | Write address; upper SECT_BITS select the sector |
| wr_data | input | DATA_W | Write data (command code) |
| erase_done | input | 1 | Erase engine finished; releases the busy states |
| chip_erase_start | output | 1 | One-cycle pulse starting a whole-bank erase |
| sector_map | output | 2**SECT_BITS | Selected-sector bitmap |
| sector_erase_start | output | 1 | One-cycle pulse when the accept window expires |
| window_expired | output | 1 | High while a sector erase runs after window expiry |

## Verification
The bench builds the decoder with `WINDOW = 8` and `SECT_BITS = 3`, keeping the other defaults. The short window lets the tests measure expiry to the exact edge. It also lets them prove that a restart happened, because eight spaced sector writes take far longer than one window. Eight sectors are few enough to fill the whole bitmap in a shuffled order and to compare it as a single byte.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2, ST_SETUP, ST_U4, ST_U5, ST_WIN, ST_CHIP, ST_SECT
  } seq_state_t;

  typedef enum logic [2:0] {
    CY_UNLOCK_A, CY_UNLOCK_B, CY_SETUP, CY_CHIP, CY_SECTOR, CY_SUSPEND, CY_OTHER
  } cyc_kind_t;

  localparam logic [10:0] ADR_HI = 11'h555;
  localparam logic [10:0] ADR_LO = 11'h2AA;
  localparam logic [7:0]  CMD_KEY_A   = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B   = 8'h55;
  localparam logic [7:0]  CMD_SETUP   = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SECTOR  = 8'h30;
  localparam logic [7:0]  CMD_SUSPEND = 8'hB0;

endpackage

// File: rtl/erase_cmd_classify.sv
module erase_cmd_classify
  import erase_seq_pkg::*;
#(
  parameter int CMD_AW = 11,
  parameter int DATA_W = 8
) (
  input  logic [CMD_AW-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output cyc_kind_t         kind
);
  logic at_hi, at_lo;

  assign at_hi = (cmd_addr == CMD_AW'(ADR_HI));
  assign at_lo = (cmd_addr == CMD_AW'(ADR_LO));

  always_comb begin
    if (cmd_data == DATA_W'(CMD_SECTOR))               kind = CY_SECTOR;
    else if (cmd_data == DATA_W'(CMD_SUSPEND))         kind = CY_SUSPEND;
    else if (at_hi && cmd_data == DATA_W'(CMD_KEY_A))  kind = CY_UNLOCK_A;
    else if (at_lo && cmd_data == DATA_W'(CMD_KEY_B))  kind = CY_UNLOCK_B;
    else if (at_hi && cmd_data == DATA_W'(CMD_SETUP))  kind = CY_SETUP;
    else if (at_hi && cmd_data == DATA_W'(CMD_CHIP))   kind = CY_CHIP;
    else                                               kind = CY_OTHER;
  end
endmodule

// File: rtl/erase_window_timer.sv
module erase_window_timer #(
  parameter int WINDOW = 16000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(WINDOW + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= CW'(WINDOW - 1);
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = run && !load && (cnt == '0);
endmodule

// File: rtl/erase_sector_map.sv
module erase_sector_map #(
  parameter int SECT_BITS = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    set_en,
  input  logic [SECT_BITS-1:0]    idx,
  output logic [2**SECT_BITS-1:0] map
);
  localparam int NSECT = 2 ** SECT_BITS;

  for (genvar i = 0; i < NSECT; i++) begin : g_bit
    logic hit;
    assign hit = set_en && (idx == SECT_BITS'(i));
    always_ff @(posedge clk) begin
      if (rst)        map[i] <= 1'b0;
      else if (clear) map[i] <= hit;
      else if (hit)   map[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/erase_seq_decoder.sv
module erase_seq_decoder
  import erase_seq_pkg::*;
#(
  parameter int CMD_AW    = 11,
  parameter int SECT_BITS = 3,
  parameter int DATA_W    = 8,
  parameter int WINDOW    = 16000,
  localparam int ADDR_W   = CMD_AW + SECT_BITS,
  localparam int NSECT    = 2 ** SECT_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_reset,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_done,
  output logic              chip_erase_start,
  output logic [NSECT-1:0]  sector_map,
  output logic              sector_erase_start,
  output logic              window_expired
);
  seq_state_t st, nxt;
  cyc_kind_t  kind;
  logic       expire, tmr_load, map_clr, map_set, chip_go, sect_go;
  logic       chip_q, sect_q;

  erase_cmd_classify #(.CMD_AW(CMD_AW), .DATA_W(DATA_W)) u_cls (
    .cmd_addr (wr_addr[CMD_AW-1:0]),
    .cmd_data (wr_data),
    .kind     (kind)
  );

  erase_window_timer #(.WINDOW(WINDOW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .run    (st == ST_WIN),
    .expire (expire)
  );

  erase_sector_map #(.SECT_BITS(SECT_BITS)) u_map (
    .clk    (clk),
    .rst    (rst),
    .clear  (map_clr),
    .set_en (map_set),
    .idx    (wr_addr[ADDR_W-1 -: SECT_BITS]),
    .map    (sector_map)
  );

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    map_clr  = 1'b0;
    map_set  = 1'b0;
    chip_go  = 1'b0;
    sect_go  = 1'b0;
    unique case (st)
      ST_IDLE:  if (wr_en) nxt = (kind == CY_UNLOCK_A) ? ST_U1    : ST_IDLE;
      ST_U1:    if (wr_en) nxt = (kind == CY_UNLOCK_B) ? ST_U2    : ST_IDLE;
      ST_U2:    if (wr_en) nxt = (kind == CY_SETUP)    ? ST_SETUP : ST_IDLE;
      ST_SETUP: if (wr_en) nxt = (kind == CY_UNLOCK_A) ? ST_U4    : ST_IDLE;
      ST_U4:    if (wr_en) nxt = (kind == CY_UNLOCK_B) ? ST_U5    : ST_IDLE;
      ST_U5: begin
        if (wr_en) begin
          if (kind == CY_CHIP) begin
            nxt     = ST_CHIP;
            chip_go = 1'b1;
          end else if (kind == CY_SECTOR) begin
            nxt      = ST_WIN;
            map_clr  = 1'b1;
            map_set  = 1'b1;
            tmr_load = 1'b1;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_WIN: begin
        if (wr_en && kind == CY_SECTOR) begin
          map_set  = 1'b1;
          tmr_load = 1'b1;
        end else if (wr_en && kind != CY_SUSPEND) begin
          map_clr = 1'b1;
          nxt     = ST_IDLE;
        end else if (expire) begin
          sect_go = 1'b1;
          nxt     = ST_SECT;
        end
      end
      ST_CHIP, ST_SECT: if (erase_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (hw_reset) begin
      nxt      = ST_IDLE;
      map_clr  = 1'b1;
      map_set  = 1'b0;
      tmr_load = 1'b0;
      chip_go  = 1'b0;
      sect_go  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      chip_q <= 1'b0;
      sect_q <= 1'b0;
    end else begin
      st     <= nxt;
      chip_q <= chip_go;
      sect_q <= sect_go;
    end
  end

  assign chip_erase_start   = chip_q;
  assign sector_erase_start = sect_q;
  assign window_expired     = (st == ST_SECT);
endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker #(
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             hw_reset,
  input logic             chip_erase_start,
  input logic [NSECT-1:0] sector_map,
  input logic             sector_erase_start,
  input logic             window_expired
);
  p_chip_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    chip_erase_start |=> !chip_erase_start);

  p_sect_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    sector_erase_start |=> !sector_erase_start);

  p_expired_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(window_expired) |-> sector_erase_start);

  p_start_map_r4: assert property (@(posedge clk) disable iff (rst)
    sector_erase_start |-> (sector_map != '0));

  p_map_hold_r9: assert property (@(posedge clk) disable iff (rst || hw_reset)
    (window_expired && $past(window_expired)) |-> $stable(sector_map));

  p_chip_excl_r10: assert property (@(posedge clk) disable iff (rst)
    chip_erase_start |-> !window_expired);
endmodule

bind erase_seq_decoder erase_seq_checker #(.NSECT(NSECT)) u_chk (
  .clk                (clk),
  .rst                (rst),
  .hw_reset           (hw_reset),
  .chip_erase_start   (chip_erase_start),
  .sector_map         (sector_map),
  .sector_erase_start (sector_erase_start),
  .window_expired     (window_expired)
);

// File: tb/test_erase_seq_decoder.sv
`timescale 1ns/1ps
module test_erase_seq_decoder;
  localparam int CMD_AW = 11;
  localparam int SB     = 3;
  localparam int DW     = 8;
  localparam int W      = 8;
  localparam int AW     = CMD_AW + SB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hw_reset = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          erase_done = 1'b0;
  logic          chip_erase_start, sector_erase_start, window_expired;
  logic [7:0]    sector_map;

  int n_checks = 0;
  int n_fails  = 0;
  int n_chip   = 0;
  int n_sect   = 0;

  always #2.5 clk = ~clk;

  erase_seq_decoder #(.CMD_AW(CMD_AW), .SECT_BITS(SB), .DATA_W(DW), .WINDOW(W)) i_erase_seq_decoder (
    .clk(clk), .rst(rst), .hw_reset(hw_reset), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .erase_done(erase_done), .chip_erase_start(chip_erase_start),
    .sector_map(sector_map), .sector_erase_start(sector_erase_start),
    .window_expired(window_expired)
  );

  always @(posedge clk) begin
    if (chip_erase_start)   n_chip <= n_chip + 1;
    if (sector_erase_start) n_sect <= n_sect + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
  endtask

  task automatic pulse_hw();
    @(negedge clk); hw_reset = 1'b1;
    @(negedge clk); hw_reset = 1'b0;
  endtask

  task automatic unlock5();
    wr(AW'(14'h555), 8'hAA); wr(AW'(14'h2AA), 8'h55); wr(AW'(14'h555), 8'h80);
    wr(AW'(14'h555), 8'hAA); wr(AW'(14'h2AA), 8'h55);
  endtask

  function automatic logic [AW-1:0] sa(input int s);
    return AW'(s) << CMD_AW;
  endfunction

  task automatic t_reset();
    check("R1 chip_start", chip_erase_start, 0);
    check("R1 sect_start", sector_erase_start, 0);
    check("R1 expired", window_expired, 0);
    check("R1 map", sector_map, 0);
  endtask

  task automatic t_chip_and_busy();
    int c0;
    unlock5(); wr(AW'(14'h555), 8'h10);
    check("R2 chip pulse high", chip_erase_start, 1);
    @(negedge clk);
    check("R2 chip pulse one cycle", chip_erase_start, 0);
    c0 = n_chip;
    unlock5(); wr(AW'(14'h555), 8'h10);
    unlock5(); wr(sa(2), 8'h30);
    idle(W + 2);
    check("R10 no chip pulse while busy", n_chip, c0);
    check("R10 map untouched while busy", sector_map, 0);
    check("R10 no window while busy", window_expired, 0);
    pulse_done();
    unlock5(); wr(AW'(14'h555), 8'h10);
    idle(1);
    check("R10 accepted after done", n_chip, c0 + 1);
    pulse_done();
  endtask

  task automatic t_bad();
    logic [AW-1:0] ga [5];
    logic [DW-1:0] gd [5];
    int c0;
    ga = '{AW'(14'h555), AW'(14'h2AA), AW'(14'h555), AW'(14'h555), AW'(14'h2AA)};
    gd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
    for (int k = 0; k < 5; k++) begin
      c0 = n_chip;
      for (int j = 0; j < 5; j++) begin
        if (j == k) wr(ga[j] ^ AW'((k % 2) ? 1 : 0), gd[j] ^ 8'((k % 2) ? 0 : 8'h01));
        else        wr(ga[j], gd[j]);
      end
      wr(AW'(14'h555), 8'h10);
      idle(1);
      check($sformatf("R3 no pulse bad cycle %0d", k), n_chip, c0);
      check("R3 map idle", sector_map, 0);
    end
    c0 = n_chip;
    unlock5(); wr(AW'(14'h555), 8'h10);
    idle(1);
    check("R3 recovered", n_chip, c0 + 1);
    pulse_done();
  endtask

  task automatic t_sector_timing();
    int s0;
    s0 = n_sect;
    unlock5(); wr(sa(3) | AW'(14'h123), 8'h30);
    check("R4 first sector", sector_map, 8'h08);
    check("R5 not expired yet", window_expired, 0);
    idle(W - 1);
    check("R5 not expired at W-1", window_expired, 0);
    check("R5 no pulse at W-1", sector_erase_start, 0);
    idle(1);
    check("R5 pulse at W", sector_erase_start, 1);
    check("R5 expired at W", window_expired, 1);
    idle(1);
    check("R5 pulse one cycle", sector_erase_start, 0);
    check("R5 expired holds", window_expired, 1);
    wr(sa(5), 8'h30);
    idle(W + 2);
    check("R9 late sector not added", sector_map, 8'h08);
    check("R9 no second pulse", n_sect, s0 + 1);
    check("R9 still expired", window_expired, 1);
    pulse_done();
    check("R5 done clears expired", window_expired, 0);
    check("R12 map held after done", sector_map, 8'h08);
    unlock5(); wr(AW'(14'h555), 8'h10);
    check("R12 map held across chip erase", sector_map, 8'h08);
    pulse_done();
  endtask

  task automatic t_multi();
    int order [8];
    order = '{6, 1, 0, 7, 3, 5, 2, 4};
    unlock5(); wr(sa(order[0]), 8'h30);
    check("R4 old map cleared", sector_map, 8'h40);
    for (int i = 1; i < 8; i++) begin
      idle(2);
      wr(sa(order[i]), 8'h30);
    end
    check("R6 all sectors", sector_map, 8'hFF);
    idle(W - 1);
    check("R6 window restarted", window_expired, 0);
    idle(1);
    check("R6 expiry after last", window_expired, 1);
    pulse_done();
  endtask

  task automatic t_suspend();
    unlock5(); wr(sa(2), 8'h30);
    idle(3);
    wr(sa(4), 8'hB0);
    check("R7 suspend no add", sector_map, 8'h04);
    idle(W - 6);
    check("R7 still open", window_expired, 0);
    idle(1);
    check("R7 no restart", window_expired, 1);
    pulse_done();
  endtask

  task automatic t_abort();
    int s0;
    s0 = n_sect;
    unlock5(); wr(sa(1), 8'h30);
    wr(AW'(14'h555), 8'hAA);
    check("R8 map cleared", sector_map, 0);
    idle(W + 2);
    check("R8 no pulse", n_sect, s0);
    check("R8 not expired", window_expired, 0);
  endtask

  task automatic t_hw();
    int c0, s0;
    unlock5(); wr(AW'(14'h555), 8'h10);
    pulse_hw();
    c0 = n_chip;
    unlock5(); wr(AW'(14'h555), 8'h10);
    idle(1);
    check("R11 chip abort then accepted", n_chip, c0 + 1);
    pulse_hw();
    s0 = n_sect;
    unlock5(); wr(sa(5), 8'h30);
    pulse_hw();
    check("R11 window map cleared", sector_map, 0);
    idle(W + 2);
    check("R11 no pulse after abort", n_sect, s0);
    unlock5(); wr(sa(7), 8'h30);
    idle(W + 1);
    check("R11 expired before hw", window_expired, 1);
    pulse_hw();
    check("R11 expired cleared", window_expired, 0);
    check("R11 map cleared", sector_map, 0);
  endtask

  initial begin
    #500000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_chip_and_busy();
    t_bad();
    t_sector_timing();
    t_multi();
    t_suspend();
    t_abort();
    t_hw();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule